// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank with Snapshot Read

This block is a bank of identical down-counting timers reached through a simple register bus. The bus has an address, write data, a write strobe, a read strobe and read data. Read data is combinational on the address during the read-strobe cycle. Each timer counts down by one per clock from a programmable start value. When it passes zero it restarts from that value, adds one to a wrap counter and records an event that can raise an interrupt. One OR-ed interrupt output covers the whole bank, next to the per-channel lines.

Software obtains a coherent count and wrap-count pair with two reads in a fixed order. Reading a channel's wrap-count register latches that channel's live count at the same clock edge. The following read of the count register returns the latched value, not the live counter. Software that wants a rising time base inverts that value.

One global enable gates every channel. A per-channel enable gates each channel on its own. Turning a channel's enable on restarts that channel's counter from its start value.

Top module: `tmr_bank`

## Requirements
- R1: Offset 0x00 reads the global enable in bit 0 and offset 0x10 reads the revision constant. Channel n (from 0) occupies the window 0x20*(n+1). Inside that window the offsets are: +0x0 control (bit 0 local enable), +0x4 start value, +0x8 latched count, +0xC wrap count, +0x10 event status (bit 0), +0x14 event clear (write-only, reads 0) and +0x18 interrupt mask (bit 0). Any other or unaligned offset reads as zero.
- R2: While the global enable is 0, no channel's counter changes.
- R3: While a channel's local enable is 0, its counter does not change, even when the global enable is 1.
- R4: When both enables are 1 and the counter is not zero, the counter decreases by exactly one per clock.
- R5: A write that sets the local enable of a stopped channel loads the counter from the start value at that edge. Counting begins on the following edge.
- R6: A read of the wrap-count register returns the current wrap count. At the same edge it latches the live counter, and later reads of the count register return that latched value until the next wrap-count read.
- R7: A running channel at zero reloads from its start value on the next edge. At that edge it also increments its wrap count by one and sets status bit 0.
- R8: A channel's interrupt line is high exactly when its status bit and its mask bit are both 1. The status bit records events whatever the mask holds.
- R9: Writing 1 to bit 0 of the clear register clears the status bit. If a wrap occurs at the same edge, the status bit stays 1.
- R10: After reset every enable, mask, status bit and wrap count is 0. The start values, counters and latched counts are all ones.
- R11: The combined interrupt output is the OR of all channel interrupt lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data for the current address |
| ch_irq | output | 4 | Masked interrupt line per channel |
| irq_any | output | 1 | OR of all channel interrupt lines |

## Verification
The assertions inside each channel check the counter rules on every clock:
- a one-step decrement while running;
- no movement while stopped;
- the reload and wrap-count increment at zero;
- status set on a wrap, winning over a clear at the same edge;
- the load from the start value when the channel is enabled;
- capture of the live count at a wrap-count read.

Only the bench scenarios can show the rest:
- the address map and the reset values seen through the bus;
- that a count read returns the earlier snapshot rather than the moving counter;
- that wrap counts survive a local stop and restart;
- mask behaviour at the interrupt pins;
- channel independence.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // register selector inside one channel window
   typedef enum logic [2:0] {
      SEL_CTRL  = 3'd0,
      SEL_START = 3'd1,
      SEL_COUNT = 3'd2,
      SEL_WRAPS = 3'd3,
      SEL_STAT  = 3'd4,
      SEL_CLR   = 3'd5,
      SEL_MASK  = 3'd6,
      SEL_NONE  = 3'd7
   } reg_sel_e;

   localparam int          WIN_LSB  = 5;      // each window spans 32 bytes
   localparam logic [4:0]  GLB_OFF  = 5'h00;
   localparam logic [4:0]  REV_OFF  = 5'h10;

   function automatic reg_sel_e decode_sel(input logic [4:0] off);
      reg_sel_e s;
      if (off[1:0] != 2'b00) begin
         s = SEL_NONE;
      end else begin
         case (off[4:2])
            3'd0:    s = SEL_CTRL;
            3'd1:    s = SEL_START;
            3'd2:    s = SEL_COUNT;
            3'd3:    s = SEL_WRAPS;
            3'd4:    s = SEL_STAT;
            3'd5:    s = SEL_CLR;
            3'd6:    s = SEL_MASK;
            default: s = SEL_NONE;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         glob_en,
   input  logic         ctrl_wr,
   input  logic         start_wr,
   input  logic         clr_wr,
   input  logic         mask_wr,
   input  logic         snap_req,
   input  logic [W-1:0] wdata,
   output logic         loc_en,
   output logic [W-1:0] start_q,
   output logic [W-1:0] snap_q,
   output logic [W-1:0] wraps_q,
   output logic         stat_q,
   output logic         mask_q,
   output logic         irq
);

   logic         run;
   logic         wrap;
   logic         launch;
   logic [W-1:0] cnt_q;

   assign run    = glob_en & loc_en;
   assign wrap   = run && (cnt_q == '0);
   assign launch = ctrl_wr && wdata[0] && !loc_en;
   assign irq    = stat_q & mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loc_en  <= 1'b0;
         start_q <= '1;
         cnt_q   <= '1;
         snap_q  <= '1;
         wraps_q <= '0;
         stat_q  <= 1'b0;
         mask_q  <= 1'b0;
      end else begin
         if (ctrl_wr)  loc_en  <= wdata[0];
         if (start_wr) start_q <= wdata;
         if (mask_wr)  mask_q  <= wdata[0];
         if (launch)
            cnt_q <= start_q;
         else if (run)
            cnt_q <= wrap ? start_q : cnt_q - 1'b1;
         if (wrap) wraps_q <= wraps_q + 1'b1;
         if (wrap)
            stat_q <= 1'b1;
         else if (clr_wr && wdata[0])
            stat_q <= 1'b0;
         if (snap_req) snap_q <= cnt_q;
      end
   end

   // R4
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R2 R3
   hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !launch) |=> $stable(cnt_q));

   // R7
   wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == $past(start_q) && wraps_q == $past(wraps_q) + 1'b1));

   // R9
   stat_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> stat_q);

   // R5
   launch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (cnt_q == $past(start_q)));

   // R6
   snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> (snap_q == $past(cnt_q)));

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
   import tmr_pkg::*;
#(
   parameter int             NUM_CH = 4,
   parameter int             W      = 32,
   parameter int             ADDR_W = 8,
   parameter logic [W-1:0]   REV_ID = '0
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                glob_en,
   input  logic [NUM_CH-1:0]   loc_en,
   input  logic [NUM_CH-1:0]   stat,
   input  logic [NUM_CH-1:0]   mask,
   input  logic [NUM_CH*W-1:0] start_v,
   input  logic [NUM_CH*W-1:0] snap_v,
   input  logic [NUM_CH*W-1:0] wraps_v,
   output logic [W-1:0]        rdata
);

   localparam int WIN_W = ADDR_W - WIN_LSB;

   logic [WIN_W-1:0] win;
   logic [4:0]       off;
   reg_sel_e         sel;

   assign win = addr[ADDR_W-1:WIN_LSB];
   assign off = addr[WIN_LSB-1:0];
   assign sel = decode_sel(off);

   always_comb begin
      rdata = '0;
      if (win == '0) begin
         if (off == GLB_OFF)      rdata = W'(glob_en);
         else if (off == REV_OFF) rdata = REV_ID;
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (win == WIN_W'(c + 1)) begin
               case (sel)
                  SEL_CTRL:  rdata = W'(loc_en[c]);
                  SEL_START: rdata = start_v[c*W +: W];
                  SEL_COUNT: rdata = snap_v[c*W +: W];
                  SEL_WRAPS: rdata = wraps_v[c*W +: W];
                  SEL_STAT:  rdata = W'(stat[c]);
                  SEL_MASK:  rdata = W'(mask[c]);
                  default:   rdata = '0;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int           NUM_CH = 4,
   parameter int           W      = 32,
   parameter int           ADDR_W = 8,
   parameter logic [W-1:0] REV_ID = W'(32'h0000_0107)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [W-1:0]      bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [W-1:0]      bus_rdata,
   output logic [NUM_CH-1:0] ch_irq,
   output logic              irq_any
);

   localparam int WIN_W = ADDR_W - WIN_LSB;

   generate
      if (NUM_CH < 1)
         $error("tmr_bank: NUM_CH must be at least 1");
      if (W < 2)
         $error("tmr_bank: W must be at least 2");
      if (ADDR_W <= WIN_LSB || (NUM_CH + 1) * 32 > (1 << ADDR_W))
         $error("tmr_bank: ADDR_W too small for NUM_CH windows");
   endgenerate

   logic [WIN_W-1:0]   win;
   logic [4:0]         off;
   reg_sel_e           sel;
   logic               glob_en_q;
   logic [NUM_CH-1:0]  loc_en, stat, mask;
   logic [NUM_CH*W-1:0] start_v, snap_v, wraps_v;

   assign win = bus_addr[ADDR_W-1:WIN_LSB];
   assign off = bus_addr[WIN_LSB-1:0];
   assign sel = decode_sel(off);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         glob_en_q <= 1'b0;
      else if (bus_wr && win == '0 && off == GLB_OFF)
         glob_en_q <= bus_wdata[0];
   end

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         logic hit;
         assign hit = (win == WIN_W'(c + 1));

         tmr_channel #(.W(W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .glob_en  (glob_en_q),
            .ctrl_wr  (bus_wr && hit && sel == SEL_CTRL),
            .start_wr (bus_wr && hit && sel == SEL_START),
            .clr_wr   (bus_wr && hit && sel == SEL_CLR),
            .mask_wr  (bus_wr && hit && sel == SEL_MASK),
            .snap_req (bus_rd && hit && sel == SEL_WRAPS),
            .wdata    (bus_wdata),
            .loc_en   (loc_en[c]),
            .start_q  (start_v[c*W +: W]),
            .snap_q   (snap_v[c*W +: W]),
            .wraps_q  (wraps_v[c*W +: W]),
            .stat_q   (stat[c]),
            .mask_q   (mask[c]),
            .irq      (ch_irq[c])
         );
      end
   endgenerate

   assign irq_any = |ch_irq;

   tmr_rdmux #(
      .NUM_CH (NUM_CH),
      .W      (W),
      .ADDR_W (ADDR_W),
      .REV_ID (REV_ID)
   ) u_rdmux (
      .addr    (bus_addr),
      .glob_en (glob_en_q),
      .loc_en  (loc_en),
      .stat    (stat),
      .mask    (mask),
      .start_v (start_v),
      .snap_v  (snap_v),
      .wraps_v (wraps_v),
      .rdata   (bus_rdata)
   );

   // R8
   irq_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_any) |-> ((stat & mask) != '0));

endmodule

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;

   localparam logic [31:0] REV = 32'h0000_0107;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_wr;
   logic        bus_rd;
   logic [31:0] bus_rdata;
   logic [3:0]  ch_irq;
   logic        irq_any;

   always #2 clk = ~clk;   // 250 MHz

   tmr_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .ch_irq    (ch_irq),
      .irq_any   (irq_any)
   );

   typedef struct {
      logic [31:0] val;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk  = 0;
   int   n_fail = 0;
   int   cyc    = 0;
   bit   done   = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic void score(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endfunction

   // monitor: pops one expected item for every read cycle
   always @(negedge clk) begin
      #1;
      if (bus_rd) begin
         if (exp_q.size() == 0) begin
            score("scoreboard underflow", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            score(e.tag, bus_rdata, e.val);
         end
      end
   end

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
      exp_t it;
      it.val = e;
      it.tag = tag;
      exp_q.push_back(it);
      bus_addr = a;
      bus_rd   = 1'b1;
      @(negedge clk);
      bus_rd   = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] cnt_at(int t, int r);
      return 32'(r - (t % (r + 1)));
   endfunction

   function automatic logic [31:0] wraps_at(int base, int t, int r);
      return 32'(base + t / (r + 1));
   endfunction

   initial begin
      int t0, t, tf, tl, base, r;
      rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 R1 reset values and map
      score("R11 irq_any after reset", {31'b0, irq_any}, 32'd0);
      score("R10 ch_irq after reset", {28'b0, ch_irq}, 32'd0);
      rd_exp(8'h00, 32'd0,        "R10 global enable");
      rd_exp(8'h10, REV,          "R1 revision");
      rd_exp(8'h24, 32'hFFFF_FFFF, "R10 start value");
      rd_exp(8'h28, 32'hFFFF_FFFF, "R10 latched count");
      rd_exp(8'h2C, 32'd0,        "R10 wrap count");
      rd_exp(8'h30, 32'd0,        "R10 status");
      rd_exp(8'h38, 32'd0,        "R10 mask");
      rd_exp(8'h20, 32'd0,        "R10 local enable");
      rd_exp(8'h14, 32'd0,        "R1 unmapped 0x14");
      rd_exp(8'h3C, 32'd0,        "R1 unmapped 0x3C");
      rd_exp(8'hA0, 32'd0,        "R1 unmapped window");
      rd_exp(8'h22, 32'd0,        "R1 unaligned");

      // R3 global on, local off: no counting
      wr_reg(8'h00, 32'd1);
      rd_exp(8'h00, 32'd1, "R1 global enable readback");
      idle(3);
      rd_exp(8'h2C, 32'd0,         "R3 wraps while local off");
      rd_exp(8'h28, 32'hFFFF_FFFF, "R3 count while local off");

      // R5 start from reload
      r = 5;
      wr_reg(8'h24, 32'd5);
      rd_exp(8'h24, 32'd5, "R1 start value readback");
      wr_reg(8'h20, 32'd1);
      t0 = cyc;
      t = cyc - t0;
      rd_exp(8'h2C, wraps_at(0, t, r), "R6 wraps at launch");
      rd_exp(8'h28, cnt_at(t, r),      "R5 count loaded from start");

      // R4 R6 R7 running, snapshot pair
      idle(9);
      t = cyc - t0;
      rd_exp(8'h2C, wraps_at(0, t, r), "R7 wraps after run");
      rd_exp(8'h28, cnt_at(t, r),      "R6 count equals snapshot");
      idle(2);
      rd_exp(8'h28, cnt_at(t, r),      "R6 snapshot held, not live");
      rd_exp(8'h30, 32'd1,             "R7 status set by wrap");
      score("R8 irq masked off", {31'b0, ch_irq[0]}, 32'd0);

      // R8 R11 mask
      wr_reg(8'h38, 32'd1);
      score("R8 irq with mask", {31'b0, ch_irq[0]}, 32'd1);
      score("R11 combined irq", {31'b0, irq_any}, 32'd1);

      // R9 clear collides with wrap
      while (((cyc - t0) % (r + 1)) != r) @(negedge clk);
      wr_reg(8'h34, 32'd1);
      rd_exp(8'h30, 32'd1, "R9 wrap wins over clear");
      while (((cyc - t0) % (r + 1)) != 2) @(negedge clk);
      wr_reg(8'h34, 32'd1);
      rd_exp(8'h30, 32'd0, "R9 clear takes effect");
      score("R8 irq low after clear", {31'b0, ch_irq[0]}, 32'd0);
      rd_exp(8'h34, 32'd0, "R1 clear reads zero");

      // R2 global freeze
      wr_reg(8'h00, 32'd0);
      tf = cyc - t0;
      idle(4);
      rd_exp(8'h2C, wraps_at(0, tf, r), "R2 wraps frozen");
      rd_exp(8'h28, cnt_at(tf, r),      "R2 count frozen");
      idle(3);
      rd_exp(8'h2C, wraps_at(0, tf, r), "R2 wraps still frozen");
      rd_exp(8'h28, cnt_at(tf, r),      "R2 count still frozen");

      // resume, then R3 local freeze
      wr_reg(8'h00, 32'd1);
      t0 = cyc - tf;
      wr_reg(8'h20, 32'd0);
      tl = cyc - t0;
      idle(3);
      rd_exp(8'h2C, wraps_at(0, tl, r), "R3 wraps frozen by local");
      rd_exp(8'h28, cnt_at(tl, r),      "R3 count frozen by local");

      // R5 R7 new start value, wraps accumulate
      base = tl / (r + 1);
      r = 2;
      wr_reg(8'h24, 32'd2);
      wr_reg(8'h20, 32'd1);
      t0 = cyc;
      idle(7);
      t = cyc - t0;
      rd_exp(8'h2C, wraps_at(base, t, r), "R7 wraps accumulate");
      rd_exp(8'h28, cnt_at(t, r),         "R5 count from new start");

      // channel 2 independence
      wr_reg(8'h64, 32'd3);
      wr_reg(8'h78, 32'd1);
      wr_reg(8'h60, 32'd1);
      idle(6);
      score("R8 channel 2 irq", {31'b0, ch_irq[2]}, 32'd1);
      score("R11 combined irq ch2", {31'b0, irq_any}, 32'd1);
      rd_exp(8'h70, 32'd1, "R7 channel 2 status");
      rd_exp(8'h50, 32'd0, "R3 channel 1 idle status");
      rd_exp(8'h4C, 32'd0, "R3 channel 1 wraps");
      score("R8 channel 1 irq", {31'b0, ch_irq[1]}, 32'd0);

      idle(2);
      if (exp_q.size() != 0) score("scoreboard leftovers", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         score("watchdog", 32'd1, 32'd0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule